// File: doc/BRIEF.md
# Machine-Mode Trap Controller

This block is the machine-level control and status register bank with interrupt entry and return logic for a core that finishes one instruction per clock. It keeps four registers: a status word holding an interrupt-enable bit and a previous-enable bit, a trap vector base, a saved return address and a cause word. Every cycle it looks at an interrupt request vector, the instruction word now executing and that instruction's address. It also looks at whether that instruction is redirecting the program counter and, if so, to where.

The redirect request and its target come straight from the inputs and the registered state, so the core can use them in the same cycle. Interrupt entry sends the core to the trap vector. The return instruction sends it back to the saved address. The register updates caused by an entry or a return happen on the next rising clock edge.

The core reads and writes the registers through a CSR port. A second read-only port gives a debugger the same registers independently of the core's port. Both read ports are combinational.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset all four registers read zero, and a non-return instruction causes no redirect.
- R2: When the request vector is nonzero, status bit 3 (enable) is 1 and the instruction is not the return word, `redirect_o` is 1 in the same cycle and `redirect_pc_o` equals the trap vector register.
- R3: On interrupt entry with `jump_i` low, the saved-address register (CSR 0x341) becomes `instr_pc_i + 4`.
- R4: On interrupt entry with `jump_i` high, the saved-address register becomes `jump_pc_i`.
- R5: On entry the cause register (CSR 0x342) becomes 0x80000007 when request bit 0 is set, and 0x8000000B when only higher request bits are set.
- R6: On entry status bit 3 clears, status bit 7 takes the old bit 3, and all other status bits are kept (0x1888 becomes 0x1880).
- R7: The instruction word 0x30200073 is the return. It raises `redirect_o` in the same cycle with `redirect_pc_o` equal to the saved address. On the next edge status bit 3 takes bit 7 and bit 7 becomes 1 (0x1880 becomes 0x1888).
- R8: A return in the same cycle as a pending enabled request is handled as a return only: the target is the saved address, and the cause and saved address are unchanged.
- R9: While status bit 3 is 0, the request vector is ignored. There is no redirect, and the status, cause and saved-address registers are unchanged.
- R10: A CSR port write to status 0x300, vector 0x305, saved address 0x341 or cause 0x342 takes effect at the next edge. `csr_rdata_o` shows the addressed register combinationally. Any other address reads zero and ignores writes.
- R11: An entry or return update wins over a same-cycle port write to a register it changes. A write to a register the event does not change still takes effect.
- R12: `dbg_rdata_o` decodes `dbg_addr_i` with the same address map as R10, independently of `csr_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flags_i | input | FLAG_W | Interrupt request vector; bit 0 is the timer request |
| instr_i | input | 32 | Instruction word executing this cycle |
| instr_pc_i | input | XLEN | Address of the executing instruction |
| jump_i | input | 1 | Executing instruction redirects the program counter |
| jump_pc_i | input | XLEN | Target of that redirect |
| csr_we_i | input | 1 | CSR port write enable |
| csr_addr_i | input | 12 | CSR port address (read and write) |
| csr_wdata_i | input | XLEN | CSR port write data |
| csr_rdata_o | output | XLEN | CSR port read data |
| dbg_addr_i | input | 12 | Debug read address |
| dbg_rdata_o | output | XLEN | Debug read data |
| redirect_o | output | 1 | Program counter must be replaced this cycle |
| redirect_pc_o | output | XLEN | Replacement program counter |

## Verification
The assertions assume that reset is applied before the first useful edge and that every input is at a known level at each rising edge. They also assume that the return is recognised only by an exact match of the full instruction word. The bench drives all inputs, including the address, data and instruction fields of idle cycles, to defined values shortly after each falling edge. It never releases an input to an unknown level. Random instruction words are steered away from the return encoding unless a return is meant. Writes to the status register are biased toward keeping the enable bit set, so that entries, returns and masked requests all occur often.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

   localparam int unsigned CSR_AW = 12;

   localparam logic [CSR_AW-1:0] ADDR_STATUS = 12'h300;
   localparam logic [CSR_AW-1:0] ADDR_VECTOR = 12'h305;
   localparam logic [CSR_AW-1:0] ADDR_RETPC  = 12'h341;
   localparam logic [CSR_AW-1:0] ADDR_CAUSE  = 12'h342;

   localparam logic [31:0] RET_WORD = 32'h3020_0073;

   localparam int unsigned BIT_EN   = 3;
   localparam int unsigned BIT_PREV = 7;

   localparam logic [3:0] CODE_TIMER = 4'd7;
   localparam logic [3:0] CODE_EXTERN = 4'd11;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_IRQ  = 2'd1,
      EV_RET  = 2'd2
   } trap_ev_e;

endpackage

// File: rtl/mtrap_arbiter.sv
module mtrap_arbiter
   import mtrap_pkg::*;
#(
   parameter int unsigned FLAG_W = 2
) (
   input  logic [FLAG_W-1:0] irq_flags_i,
   input  logic [31:0]       instr_i,
   input  logic              en_i,
   output trap_ev_e          ev_o,
   output logic [3:0]        code_o
);

   logic is_ret;
   logic pending;

   assign is_ret  = (instr_i == RET_WORD);
   assign pending = |irq_flags_i;

   // the timer request (bit 0) is served ahead of every other request
   assign code_o = irq_flags_i[0] ? CODE_TIMER : CODE_EXTERN;

   // the return instruction wins over a simultaneous request
   always_comb begin
      if (is_ret)                ev_o = EV_RET;
      else if (pending && en_i)  ev_o = EV_IRQ;
      else                       ev_o = EV_NONE;
   end

endmodule

// File: rtl/mtrap_csr_bank.sv
module mtrap_csr_bank
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned NRD  = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  trap_ev_e                    ev_i,
   input  logic [3:0]                  code_i,
   input  logic [XLEN-1:0]             ret_pc_i,
   input  logic                        we_i,
   input  logic [CSR_AW-1:0]           waddr_i,
   input  logic [XLEN-1:0]             wdata_i,
   input  logic [NRD-1:0][CSR_AW-1:0]  raddr_i,
   output logic [NRD-1:0][XLEN-1:0]    rdata_o,
   output logic                        en_o,
   output logic [XLEN-1:0]             vector_o,
   output logic [XLEN-1:0]             retpc_o
);

   localparam int unsigned PAD_W = XLEN - 5;

   logic [XLEN-1:0] status_q, vector_q, retpc_q, cause_q;

   function automatic logic [XLEN-1:0] decode(input logic [CSR_AW-1:0] a,
                                              input logic [XLEN-1:0] st,
                                              input logic [XLEN-1:0] vc,
                                              input logic [XLEN-1:0] rp,
                                              input logic [XLEN-1:0] ca);
      case (a)
         ADDR_STATUS: return st;
         ADDR_VECTOR: return vc;
         ADDR_RETPC:  return rp;
         ADDR_CAUSE:  return ca;
         default:     return '0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         vector_q <= '0;
         retpc_q  <= '0;
         cause_q  <= '0;
      end else begin
         if (we_i && waddr_i == ADDR_VECTOR) vector_q <= wdata_i;
         if (we_i && waddr_i == ADDR_STATUS && ev_i == EV_NONE) status_q <= wdata_i;
         if (we_i && waddr_i == ADDR_RETPC  && ev_i != EV_IRQ)  retpc_q  <= wdata_i;
         if (we_i && waddr_i == ADDR_CAUSE  && ev_i != EV_IRQ)  cause_q  <= wdata_i;
         case (ev_i)
            EV_IRQ: begin
               retpc_q            <= ret_pc_i;
               cause_q            <= {1'b1, {PAD_W{1'b0}}, code_i};
               status_q[BIT_EN]   <= 1'b0;
               status_q[BIT_PREV] <= status_q[BIT_EN];
            end
            EV_RET: begin
               status_q[BIT_EN]   <= status_q[BIT_PREV];
               status_q[BIT_PREV] <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata_o[g] = decode(raddr_i[g], status_q, vector_q, retpc_q, cause_q);
   end

   assign en_o     = status_q[BIT_EN];
   assign vector_o = vector_q;
   assign retpc_o  = retpc_q;

   // R6: entry clears the enable and saves it as previous-enable
   a_r6_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_IRQ) |=> (!status_q[BIT_EN] && status_q[BIT_PREV]));
   // R7: return restores the enable and sets previous-enable
   a_r7_ret_status: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_RET) |=> (status_q[BIT_EN] == $past(status_q[BIT_PREV]) && status_q[BIT_PREV]));
   // R3: entry records the supplied return address
   a_r3_retpc: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_IRQ) |=> (retpc_q == $past(ret_pc_i)));
   // R5: entry marks the cause as an interrupt
   a_r5_cause_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_IRQ) |=> cause_q[XLEN-1]);
   // R10: vector writes land on the next edge
   a_r10_vector_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && waddr_i == ADDR_VECTOR) |=> (vector_q == $past(wdata_i)));
   // R8: a return leaves the cause alone unless the port writes it
   a_r8_ret_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_RET && !(we_i && waddr_i == ADDR_CAUSE)) |=> $stable(cause_q));

endmodule

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
   import mtrap_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned FLAG_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] irq_flags_i,
   input  logic [31:0]       instr_i,
   input  logic [XLEN-1:0]   instr_pc_i,
   input  logic              jump_i,
   input  logic [XLEN-1:0]   jump_pc_i,
   input  logic              csr_we_i,
   input  logic [11:0]       csr_addr_i,
   input  logic [XLEN-1:0]   csr_wdata_i,
   output logic [XLEN-1:0]   csr_rdata_o,
   input  logic [11:0]       dbg_addr_i,
   output logic [XLEN-1:0]   dbg_rdata_o,
   output logic              redirect_o,
   output logic [XLEN-1:0]   redirect_pc_o
);

   localparam int unsigned NRD  = 2;
   localparam int unsigned STEP = 4;

   if (XLEN < 32) begin : g_bad_xlen
      $error("mtrap_ctrl: XLEN must be at least 32");
   end
   if (FLAG_W < 1) begin : g_bad_flags
      $error("mtrap_ctrl: FLAG_W must be at least 1");
   end

   trap_ev_e                    ev;
   logic [3:0]                  code;
   logic                        en;
   logic [XLEN-1:0]             vector, retpc, next_pc;
   logic [NRD-1:0][CSR_AW-1:0]  raddr;
   logic [NRD-1:0][XLEN-1:0]    rdata;

   assign next_pc  = jump_i ? jump_pc_i : instr_pc_i + XLEN'(STEP);
   assign raddr[0] = csr_addr_i;
   assign raddr[1] = dbg_addr_i;
   assign csr_rdata_o = rdata[0];
   assign dbg_rdata_o = rdata[1];

   mtrap_arbiter #(.FLAG_W(FLAG_W)) arb_i (
      .irq_flags_i (irq_flags_i),
      .instr_i     (instr_i),
      .en_i        (en),
      .ev_o        (ev),
      .code_o      (code)
   );

   mtrap_csr_bank #(.XLEN(XLEN), .NRD(NRD)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev),
      .code_i   (code),
      .ret_pc_i (next_pc),
      .we_i     (csr_we_i),
      .waddr_i  (csr_addr_i),
      .wdata_i  (csr_wdata_i),
      .raddr_i  (raddr),
      .rdata_o  (rdata),
      .en_o     (en),
      .vector_o (vector),
      .retpc_o  (retpc)
   );

   assign redirect_o    = (ev != EV_NONE);
   assign redirect_pc_o = (ev == EV_RET) ? retpc : vector;

   // R9: with the enable clear only a return may redirect
   a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && instr_i != RET_WORD) |-> !redirect_o);
   // R7: the return targets the saved address
   a_r7_ret_target: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i == RET_WORD) |-> (redirect_o && redirect_pc_o == retpc));
   // R2: an enabled request redirects to the vector
   a_r2_entry_target: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (|irq_flags_i) && instr_i != RET_WORD) |-> (redirect_o && redirect_pc_o == vector));

endmodule

// File: tb/mtrap_ctrl_tb_top.sv
`timescale 1ns/1ps
module mtrap_ctrl_tb_top;

   localparam logic [31:0] RETW = 32'h3020_0073;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  flags = '0;
   logic [31:0] instr = 32'h13;
   logic [31:0] pc = '0;
   logic        jmp = 1'b0;
   logic [31:0] jpc = '0;
   logic        we = 1'b0;
   logic [11:0] caddr = '0;
   logic [31:0] wdata = '0;
   logic [11:0] daddr = '0;
   logic [31:0] crd, drd, rpc;
   logic        red;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_st = '0, m_vec = '0, m_epc = '0, m_cause = '0;

   always #2 clk = ~clk;

   mtrap_ctrl #(.XLEN(32), .FLAG_W(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_flags_i(flags), .instr_i(instr),
      .instr_pc_i(pc), .jump_i(jmp), .jump_pc_i(jpc), .csr_we_i(we),
      .csr_addr_i(caddr), .csr_wdata_i(wdata), .csr_rdata_o(crd),
      .dbg_addr_i(daddr), .dbg_rdata_o(drd), .redirect_o(red),
      .redirect_pc_o(rpc)
   );

   function automatic logic [31:0] mread(input logic [11:0] a);
      case (a)
         12'h300: return m_st;
         12'h305: return m_vec;
         12'h341: return m_epc;
         12'h342: return m_cause;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string rtag, input logic [1:0] fl, input logic [31:0] ins,
                      input logic [31:0] p, input logic j, input logic [31:0] jp,
                      input logic w, input logic [11:0] ca, input logic [31:0] wd,
                      input logic [11:0] da);
      logic is_ret, take;
      string etag;
      @(negedge clk);
      flags = fl; instr = ins; pc = p; jmp = j; jpc = jp;
      we = w; caddr = ca; wdata = wd; daddr = da;
      #1;
      is_ret = (ins == RETW);
      take   = !is_ret && m_st[3] && (fl != 2'b00);
      if (is_ret)          etag = (fl != 2'b00) ? "R8" : "R7";
      else if (take)       etag = "R2";
      else if (fl != 2'b00) etag = "R9";
      else                 etag = "R1";
      chk(etag, "redirect", {31'b0, red}, {31'b0, is_ret || take});
      if (is_ret || take) chk(etag, "target", rpc, is_ret ? m_epc : m_vec);
      chk(rtag, "csr_rdata", crd, mread(ca));
      chk(rtag == "R10" ? "R12" : rtag, "dbg_rdata", drd, mread(da));
      if (w) begin
         if (ca == 12'h305) m_vec = wd;
         if (ca == 12'h300 && !take && !is_ret) m_st = wd;
         if (ca == 12'h341 && !take) m_epc = wd;
         if (ca == 12'h342 && !take) m_cause = wd;
      end
      if (take) begin
         m_epc   = j ? jp : p + 32'd4;
         m_cause = fl[0] ? 32'h8000_0007 : 32'h8000_000B;
         m_st[7] = m_st[3];
         m_st[3] = 1'b0;
      end else if (is_ret) begin
         m_st[3] = m_st[7];
         m_st[7] = 1'b1;
      end
   endtask

   localparam logic [31:0] NOP = 32'h0000_0013;

   initial begin : main
      logic [11:0] alist [6];
      alist[0] = 12'h300; alist[1] = 12'h305; alist[2] = 12'h341;
      alist[3] = 12'h342; alist[4] = 12'h344; alist[5] = 12'h123;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cyc("R1", 0, NOP, 0, 0, 0, 0, 12'h300, 0, 12'h305);
      cyc("R1", 0, NOP, 0, 0, 0, 0, 12'h341, 0, 12'h342);
      // R10 writes
      cyc("R10", 0, NOP, 0, 0, 0, 1, 12'h305, 32'h1144, 12'h300);
      cyc("R10", 0, NOP, 0, 0, 0, 1, 12'h300, 32'h1888, 12'h305);
      cyc("R10", 0, NOP, 0, 0, 0, 0, 12'h300, 0, 12'h305);
      // R2 entry, R3 return address, R5 timer cause, R6 status
      cyc("R2", 2'b01, NOP, 32'h1900, 0, 32'h55, 0, 12'h300, 0, 12'h305);
      cyc("R3", 0, NOP, 0, 0, 0, 0, 12'h341, 0, 12'h342);
      cyc("R6", 0, NOP, 0, 0, 0, 0, 12'h300, 0, 12'h342);
      // R7 return
      cyc("R7", 0, RETW, 32'h2000, 0, 0, 0, 12'h300, 0, 12'h341);
      cyc("R7", 0, NOP, 0, 0, 0, 0, 12'h300, 0, 12'h300);
      // R4 jump target, R5 external cause
      cyc("R4", 2'b10, NOP, 32'h1980, 1, 32'h1990, 0, 12'h341, 0, 12'h342);
      cyc("R4", 0, NOP, 0, 0, 0, 0, 12'h341, 0, 12'h342);
      cyc("R5", 0, RETW, 0, 0, 0, 0, 12'h342, 0, 12'h300);
      // R5 both requests: timer first
      cyc("R5", 2'b11, NOP, 32'h3000, 0, 0, 0, 12'h300, 0, 12'h300);
      cyc("R5", 0, NOP, 0, 0, 0, 0, 12'h342, 0, 12'h341);
      cyc("R7", 0, RETW, 0, 0, 0, 0, 12'h300, 0, 12'h300);
      // R9 masked request
      cyc("R9", 0, NOP, 0, 0, 0, 1, 12'h300, 32'h0000_1800, 12'h300);
      cyc("R9", 2'b01, NOP, 32'h4000, 0, 0, 0, 12'h341, 0, 12'h342);
      cyc("R9", 2'b10, NOP, 32'h4004, 1, 32'h8, 0, 12'h300, 0, 12'h341);
      // R8 return beats a pending request
      cyc("R8", 0, NOP, 0, 0, 0, 1, 12'h300, 32'h1888, 12'h300);
      cyc("R8", 2'b01, RETW, 32'h5000, 0, 0, 0, 12'h342, 0, 12'h341);
      cyc("R8", 0, NOP, 0, 0, 0, 0, 12'h342, 0, 12'h341);
      // R11 event wins over same-register write; other registers still written
      cyc("R11", 2'b01, NOP, 32'h6000, 0, 0, 1, 12'h300, 32'hFFFF_0000, 12'h300);
      cyc("R11", 0, NOP, 0, 0, 0, 0, 12'h300, 0, 12'h342);
      cyc("R11", 0, NOP, 0, 0, 0, 1, 12'h300, 32'h1888, 12'h300);
      cyc("R11", 2'b10, NOP, 32'h7000, 0, 0, 1, 12'h305, 32'h2000, 12'h305);
      cyc("R11", 0, NOP, 0, 0, 0, 0, 12'h305, 0, 12'h341);
      cyc("R11", 0, RETW, 0, 0, 0, 1, 12'h341, 32'h9000, 12'h341);
      cyc("R11", 0, NOP, 0, 0, 0, 0, 12'h341, 0, 12'h300);
      // R10 unimplemented addresses
      cyc("R10", 0, NOP, 0, 0, 0, 1, 12'h123, 32'hDEAD_BEEF, 12'h344);
      cyc("R10", 0, NOP, 0, 0, 0, 0, 12'h123, 0, 12'h344);
      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [1:0]  fl;
         logic [31:0] ins, wd;
         logic [11:0] ca;
         logic        w;
         fl  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
         ins = $urandom;
         if (ins == RETW) ins = ins ^ 32'h1;
         if ($urandom % 8 == 0) ins = RETW;
         w   = ($urandom % 3 == 0);
         ca  = alist[$urandom % 6];
         wd  = $urandom;
         if (ca == 12'h300 && ($urandom % 4 != 0)) wd[3] = 1'b1;
         cyc("R10", fl, ins, {$urandom} & 32'hFFFF_FFFC, 1'($urandom),
             {$urandom} & 32'hFFFF_FFFC, w, ca, wd, alist[$urandom % 6]);
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule